// File: doc/BRIEF.md
# Timer Input Capture Unit

The block runs a 16-bit free-running count and has four input capture channels. Each channel samples an external pin through a two-stage synchronizer and watches it for an edge of a programmable polarity. When an edge qualifies, the channel copies the present count into its own 16-bit capture register in one parallel transfer. Software picks the polarity for each channel through one 8-bit control register. It reads the capture registers as a high byte and a low byte over a simple 8-bit register bus.

Reads are made coherent by an interlock. During a bus cycle that reads a channel's high byte, no capture may be transferred into that channel. A capture that qualifies in that cycle is parked together with the count seen at detection and is written one cycle later. The low byte read that follows therefore belongs to the same capture as the high byte, and no event is lost. The fourth channel can only capture while a separate enable input is high.

Top module: `icap_unit`

## Requirements
- R1: Each channel has a 2-bit polarity field with these codes: 00 means never capture, 01 means rising edges only, 10 means falling edges only and 11 means both edges.
- R2: The control register is read and written at address 0. Its bits [7:6] select the mode of channel 3 (the fourth channel). Bits [5:4] serve channel 0, bits [3:2] channel 1 and bits [1:0] channel 2. Reset clears the whole register to 0.
- R3: `cnt_o` is 0 while reset is held and just after it is released. It then rises by exactly 1 on every clock and wraps from 0xFFFF to 0x0000.
- R4: Suppose a pin changes between two rising clock edges, and `cnt_o` equals V at that moment. A qualifying edge then loads V+2 (modulo 2^16) into the capture register, and the new value is readable from the third clock edge after the pin change.
- R5: Channel k has its high byte at address 2+2k and its low byte at address 3+2k. Writes to these addresses have no effect, and any unmapped address reads 0.
- R6: No capture is transferred into a channel at the end of a cycle in which that channel's high byte is being read. A low-byte read in the following cycle therefore returns the byte that pairs with the earlier high byte.
- R7: A capture blocked under R6 is written one cycle later. It carries the count from the cycle in which the edge was detected and is not dropped.
- R8: The channels work independently of one another. If edges on several pins are detected in the same cycle, every enabled channel captures the same count.
- R9: Channel 3 does not capture while `ch4_en_i` is low, whatever its mode field says.
- R10: Reset leaves the contents of the capture registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4 | Asynchronous capture inputs, one per channel |
| ch4_en_i | input | 1 | Enables channel 3 to capture |
| addr_i | input | 4 | Register address |
| rd_i | input | 1 | Read strobe for the current cycle |
| we_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| cnt_o | output | 16 | Free-running count |

## Verification
A capture transfer into a channel can land in the same cycle as a bus read of that channel's high byte. The bench forces this collision by changing a pin and then issuing the high-byte read exactly two edges later, which is the cycle in which the synchronized edge is detected. The bench passes this case only if three things hold. The high byte and the low byte read in the next cycle must both still belong to the older capture. The capture value that follows must be the count predicted for the original pin change. Neither an early transfer nor a lost event nor a later count is accepted. A second collision puts two channels' edges in the same cycle, and each channel must latch the same count.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int unsigned NCH = 4;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // last channel sits at the top field, the rest descend from just below it
  function automatic int unsigned fld_lsb(int unsigned ch);
    return (ch == NCH - 1) ? 2 * (NCH - 1) : 2 * (NCH - 2) - 2 * ch;
  endfunction
endpackage

// File: rtl/icap_edge.sv
module icap_edge
  import icap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  edge_sel_e sel_i,
  input  logic      en_i,
  output logic      hit_o
);
  logic s1_q, s2_q, prev_q;
  logic rise, fall, match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_OFF:  match = 1'b0;
      EDGE_RISE: match = rise;
      EDGE_FALL: match = fall;
      EDGE_BOTH: match = rise | fall;
    endcase
  end

  assign hit_o = en_i & match;
endmodule

// File: rtl/icap_chan.sv
module icap_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             block_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             pend_o,
  output logic [CNT_W-1:0] pend_val_o
);
  logic [CNT_W-1:0] cap_q, pend_val_q, load_val;
  logic             pend_q, load;

  always_comb begin
    load     = 1'b0;
    load_val = cnt_i;
    if (!block_i) begin
      if (hit_i) begin
        load = 1'b1;
      end else if (pend_q) begin
        load     = 1'b1;
        load_val = pend_val_q;
      end
    end
  end

  // capture contents survive reset
  always_ff @(posedge clk_i) begin
    if (load) cap_q <= load_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else if (block_i) begin
      if (hit_i) begin
        pend_q     <= 1'b1;
        pend_val_q <= cnt_i;
      end
    end else begin
      pend_q <= 1'b0;
    end
  end

  assign cap_o      = cap_q;
  assign pend_o     = pend_q;
  assign pend_val_o = pend_val_q;
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    pin_i,
  input  logic              ch4_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int unsigned CTRL_W = 2 * NCH;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  logic [CTRL_W-1:0]           ctrl_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [NCH-1:0]              hit, block, pend_q;
  logic [NCH-1:0][CNT_W-1:0]   cap_q, pend_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ctrl_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (we_i && addr_i == CTRL_ADDR) ctrl_q <= wdata_i[CTRL_W-1:0];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int unsigned LSB = fld_lsb(ch);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(2 + 2 * ch);
    logic en;

    if (ch == NCH - 1) begin : g_gated
      assign en = ch4_en_i;
    end else begin : g_free
      assign en = 1'b1;
    end

    assign block[ch] = rd_i && addr_i == HI_ADDR;

    icap_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[ch]),
      .sel_i  (edge_sel_e'(ctrl_q[LSB +: 2])),
      .en_i   (en),
      .hit_o  (hit[ch])
    );

    icap_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_i      (hit[ch]),
      .block_i    (block[ch]),
      .cnt_i      (cnt_q),
      .cap_o      (cap_q[ch]),
      .pend_o     (pend_q[ch]),
      .pend_val_o (pend_val[ch])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) rdata_o = DATA_W'(ctrl_q);
    for (int ch = 0; ch < NCH; ch++) begin
      if (addr_i == ADDR_W'(2 + 2 * ch)) rdata_o = cap_q[ch][CNT_W-1:DATA_W];
      if (addr_i == ADDR_W'(3 + 2 * ch)) rdata_o = cap_q[ch][DATA_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      rd_i,
  input logic                      we_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic                      ch4_en_i,
  input logic [CNT_W-1:0]          cnt_q,
  input logic [CTRL_W-1:0]         ctrl_q,
  input logic [NCH-1:0]            hit,
  input logic [NCH-1:0]            pend_q,
  input logic [NCH-1:0][CNT_W-1:0] cap_q,
  input logic [NCH-1:0][CNT_W-1:0] pend_val
);
  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  assert_ctrl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == '0) |=> $stable(ctrl_q));

  assert_ch4_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ch4_en_i && !pend_q[NCH-1]) |=> $stable(cap_q[NCH-1]));

  for (genvar c = 0; c < NCH; c++) begin : g_a
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(2 + 2 * c);

    assert_hi_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && addr_i == HI) |=> $stable(cap_q[c]));

    assert_late_xfer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[c] && !hit[c] && !(rd_i && addr_i == HI)) |=> cap_q[c] == $past(pend_val[c]));

    assert_fresh_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit[c] && !(rd_i && addr_i == HI)) |=> cap_q[c] == $past(cnt_q));

    assert_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hit[c] && !pend_q[c]) |=> $stable(cap_q[c]));
  end
endmodule

bind icap_unit icap_unit_chk #(
  .NCH(icap_pkg::NCH), .CNT_W(CNT_W), .CTRL_W(2 * icap_pkg::NCH), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (rd_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .ch4_en_i (ch4_en_i),
  .cnt_q    (cnt_q),
  .ctrl_q   (ctrl_q),
  .hit      (hit),
  .pend_q   (pend_q),
  .cap_q    (cap_q),
  .pend_val (pend_val)
);

// File: tb/icap_unit_bench.sv
module icap_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pins = '0;
  logic        en4 = 1'b1;
  logic [3:0]  addr = '0;
  logic        rd = 1'b0, we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] cnt;
  logic [15:0] exp_cap [4];
  int n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  icap_unit u_icap_unit (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .ch4_en_i(en4),
    .addr_i(addr), .rd_i(rd), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .cnt_o(cnt)
  );

  function automatic int lsb_of(int ch);
    return (ch == 3) ? 6 : 4 - 2 * ch;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_byte(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic rd_cap(int ch, output logic [15:0] v);
    logic [7:0] hi, lo;
    rd_byte(4'(2 + 2 * ch), hi);
    rd_byte(4'(3 + 2 * ch), lo);
    v = {hi, lo};
  endtask

  // flips the masked pins; returns the count a capture must hold
  task automatic flip(logic [3:0] mask, output logic [15:0] v);
    @(negedge clk);
    v = cnt + 16'd2;
    pins = pins ^ mask;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #1_900_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v, got, c0;
    logic [7:0]  b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 count in reset", 32'(cnt), 0);
    rst_n = 1'b1;
    #1 chk("R3 count at release", 32'(cnt), 0);
    rd_byte(4'd0, b);
    chk("R2 control reset", 32'(b), 0);

    // sweep every channel, mode and edge direction
    for (int ch = 0; ch < 4; ch++) begin
      for (int m = 3; m >= 0; m--) begin
        wr(4'd0, 8'(m << lsb_of(ch)));
        rd_byte(4'd0, b);
        chk("R2 control readback", 32'(b), 32'(m << lsb_of(ch)));
        for (int dir = 0; dir < 2; dir++) begin
          logic rising;
          rising = !pins[ch];
          flip(4'(1 << ch), v);
          if ((rising && m[0]) || (!rising && m[1])) exp_cap[ch] = v;
          rd_cap(ch, got);
          chk(rising ? "R1 R4 rising sweep" : "R1 R4 falling sweep", 32'(got), 32'(exp_cap[ch]));
        end
      end
    end

    // writes to capture bytes ignored, unmapped reads zero
    wr(4'd4, 8'h5A);
    wr(4'd5, 8'hA5);
    rd_cap(1, got);
    chk("R5 capture write ignored", 32'(got), 32'(exp_cap[1]));
    rd_byte(4'd15, b);
    chk("R5 unmapped reads zero", 32'(b), 0);

    // simultaneous edges on two channels
    wr(4'd0, 8'hFF);
    flip(4'b0011, v);
    exp_cap[0] = v; exp_cap[1] = v;
    rd_cap(0, got);
    chk("R8 same count ch0", 32'(got), 32'(v));
    rd_cap(1, got);
    chk("R8 same count ch1", 32'(got), 32'(v));

    // high-byte read collides with the detection cycle of channel 1
    @(negedge clk);
    v = cnt + 16'd2;
    pins[1] = ~pins[1];
    @(negedge clk);
    @(negedge clk); rd = 1'b1; addr = 4'd4;
    #1 chk("R6 high byte kept", 32'(rdata), 32'(exp_cap[1][15:8]));
    @(negedge clk); addr = 4'd5;
    #1 chk("R6 low byte coherent", 32'(rdata), 32'(exp_cap[1][7:0]));
    @(negedge clk); rd = 1'b0;
    exp_cap[1] = v;
    rd_cap(1, got);
    chk("R7 delayed capture value", 32'(got), 32'(v));

    // channel 3 gating
    en4 = 1'b0;
    flip(4'b1000, v);
    rd_cap(3, got);
    chk("R9 gated channel unchanged", 32'(got), 32'(exp_cap[3]));
    en4 = 1'b1;
    flip(4'b1000, v);
    exp_cap[3] = v;
    rd_cap(3, got);
    chk("R9 enabled channel captures", 32'(got), 32'(v));

    // reset preserves captures
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R3 count after reset", 32'(cnt), 0);
    rd_byte(4'd0, b);
    chk("R2 control cleared", 32'(b), 0);
    for (int ch = 0; ch < 4; ch++) begin
      rd_cap(ch, got);
      chk("R10 capture survives reset", 32'(got), 32'(exp_cap[ch]));
    end

    // count step and wrap
    @(negedge clk); c0 = cnt;
    repeat (5) @(negedge clk);
    chk("R3 count step", 32'(cnt), 32'(16'(c0 + 16'd5)));
    c0 = cnt;
    repeat (65536) @(negedge clk);
    chk("R3 count wrap", 32'(cnt), 32'(c0));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule